// File: doc/BRIEF.md
# Fetch-Stage Branch Direction and Target Predictor

This block sits beside the fetch stage and guesses, for each fetch address, whether the instruction there is a branch that will be taken, and if so where it goes. Two structures are used together. The first is a direct-mapped table of two-bit saturating counters, indexed by low-order address bits and carrying no tags. The second is a small tagged cache of branch destinations. A lookup is predicted taken only when its counter leans taken and its address also hits in the destination cache. In that case the predicted next fetch address is the cached destination. In every other case it is the fetch address plus four.

Resolved branches come back from later in the pipeline on an update port, which is sampled at the clock edge. A taken outcome moves the counter up and records the destination, tag and valid flag. A not-taken outcome only moves the counter down. Because the counters saturate, a strongly biased entry needs two wrong outcomes in a row before its predicted direction changes. Lookups read the stored state combinationally, so a lookup in the same cycle as an update sees the state from before that update.

The lookup side is a pass-through valid/ready stream with no storage. `pred_valid` follows `fetch_valid`, and `fetch_ready` follows `pred_ready`. When the consumer holds `pred_ready` low, the producer must keep `fetch_pc` steady. The prediction outputs are a pure function of `fetch_pc` and the stored state, whether or not valid is high. The update side never applies back-pressure: `upd_ready` is always 1, and every cycle with `upd_valid` high trains the tables at that clock edge.

Top module: `bp_fetch_predictor`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) sets every counter to weakly not taken (01) and clears every destination-cache valid flag. After reset, every lookup returns `pred_taken`=0 and `pred_npc`=`fetch_pc`+4.
- R2: Counter encoding is 00 strongly not taken, 01 weakly not taken, 10 weakly taken and 11 strongly taken. An update with outcome taken increments the counter and saturates at 11. An update with outcome not taken decrements it and saturates at 00.
- R3: The counter is selected by PC[7:2] alone. Two addresses that agree in bits 7:2 share one counter, whatever their other bits are.
- R4: The destination-cache entry is selected by PC[5:2]. It hits only if it is valid and its stored tag equals PC[31:6].
- R5: `pred_taken` is 1 exactly when the selected counter's upper bit is 1 and the destination cache hits. `pred_npc` is the cached destination when `pred_taken` is 1, and `fetch_pc`+4 otherwise.
- R6: A taken update writes its destination, tag and valid flag into the entry selected by its PC. A not-taken update leaves the destination cache unchanged.
- R7: Starting from a strongly taken entry, the predicted direction stays taken after one not-taken outcome and turns not taken after the second.
- R8: A lookup in the same cycle as an update to the same entries returns the contents from before that update. The new contents are visible from the next cycle on.
- R9: `pred_valid` equals `fetch_valid`, `fetch_ready` equals `pred_ready`, and `upd_ready` is 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_valid | input | 1 | Lookup request valid |
| fetch_ready | output | 1 | Lookup request ready (mirrors pred_ready) |
| fetch_pc | input | 32 | Fetch address to predict |
| pred_valid | output | 1 | Prediction valid (mirrors fetch_valid) |
| pred_ready | input | 1 | Consumer ready for the prediction |
| pred_taken | output | 1 | Predicted taken |
| pred_npc | output | 32 | Predicted next fetch address |
| upd_valid | input | 1 | Resolved-branch update present |
| upd_ready | output | 1 | Always 1: updates are never refused |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 for taken |
| upd_target | input | 32 | Actual destination of the branch |

## Verification
The assertions assume that `rst` is held for at least one clock edge before any update, and that the update inputs are at known values whenever `upd_valid` is high. The counter assertions also assume each update has a single target entry per cycle, which the port structure guarantees. The stimulus applies reset first and then changes all inputs only on the falling edge. It draws fetch and update addresses from a small pool of upper-address patterns, so that index aliasing, tag mismatches and repeated training of the same entries happen often while every field stays defined.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam logic [1:0] CTR_SNT = 2'b00;
  localparam logic [1:0] CTR_WNT = 2'b01;
  localparam logic [1:0] CTR_WT  = 2'b10;
  localparam logic [1:0] CTR_ST  = 2'b11;

  function automatic logic [1:0] ctr_next(input logic [1:0] cur, input logic taken);
    logic [1:0] nxt;
    if (taken) nxt = (cur == CTR_ST)  ? CTR_ST  : cur + 2'd1;
    else       nxt = (cur == CTR_SNT) ? CTR_SNT : cur - 2'd1;
    return nxt;
  endfunction
endpackage

// File: rtl/bp_dir_table.sv
module bp_dir_table #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [1:0]       rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  import bp_pkg::*;
  localparam int N = 1 << IDX_W;

  logic [1:0] ctr_q [N];
  logic [1:0] wr_old;

  assign wr_old = ctr_q[wr_idx];
  assign rd_ctr = ctr_q[rd_idx];

  for (genvar i = 0; i < N; i++) begin : g_ctr
    always_ff @(posedge clk) begin
      if (rst)
        ctr_q[i] <= CTR_WNT;
      else if (wr_en && (wr_idx == IDX_W'(i)))
        ctr_q[i] <= ctr_next(ctr_q[i], wr_taken);
    end
  end

  // R2: a taken update below the top moves the entry up by one
  assert_ctr_inc_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_taken && wr_old != CTR_ST) |=> ctr_q[$past(wr_idx)] == $past(wr_old) + 2'd1);
  // R2: a not-taken update above the bottom moves the entry down by one
  assert_ctr_dec_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_taken && wr_old != CTR_SNT) |=> ctr_q[$past(wr_idx)] == $past(wr_old) - 2'd1);
  // R2: both ends saturate
  assert_ctr_sat_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_old == (wr_taken ? CTR_ST : CTR_SNT))) |=> ctr_q[$past(wr_idx)] == $past(wr_old));
endmodule

// File: rtl/bp_target_buf.sv
module bp_target_buf #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] rd_pc,
  output logic            rd_hit,
  output logic [PC_W-1:0] rd_tgt,
  input  logic            wr_en,
  input  logic [PC_W-1:0] wr_pc,
  input  logic [PC_W-1:0] wr_tgt
);
  localparam int N     = 1 << IDX_W;
  localparam int LO    = 2;
  localparam int TAG_W = PC_W - IDX_W - LO;

  logic [N-1:0]      valid_q;
  logic [TAG_W-1:0]  tag_q [N];
  logic [PC_W-1:0]   tgt_q [N];

  logic [IDX_W-1:0]  rd_idx, wr_idx;
  logic [TAG_W-1:0]  rd_tag, wr_tag;

  assign rd_idx = rd_pc[IDX_W+LO-1:LO];
  assign rd_tag = rd_pc[PC_W-1:IDX_W+LO];
  assign wr_idx = wr_pc[IDX_W+LO-1:LO];
  assign wr_tag = wr_pc[PC_W-1:IDX_W+LO];

  assign rd_hit = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign rd_tgt = tgt_q[rd_idx];

  for (genvar i = 0; i < N; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        valid_q[i] <= 1'b0;
        tag_q[i]   <= '0;
        tgt_q[i]   <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(i))) begin
        valid_q[i] <= 1'b1;
        tag_q[i]   <= wr_tag;
        tgt_q[i]   <= wr_tgt;
      end
    end
  end

  // R6: a write leaves its entry valid
  assert_btb_fill_R6: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> valid_q[$past(wr_idx)]);
  // R6: without a write the valid flags hold
  assert_btb_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(valid_q));
endmodule

// File: rtl/bp_fetch_predictor.sv
module bp_fetch_predictor #(
  parameter int PC_W      = 32,
  parameter int DIR_IDX_W = 6,
  parameter int BTB_IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fetch_valid,
  output logic            fetch_ready,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            pred_valid,
  input  logic            pred_ready,
  output logic            pred_taken,
  output logic [PC_W-1:0] pred_npc,
  input  logic            upd_valid,
  output logic            upd_ready,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target
);
  localparam int LO = 2;

  logic [1:0]      ctr;
  logic            hit;
  logic [PC_W-1:0] btb_tgt;
  logic            upd_fire;

  assign upd_ready   = 1'b1;
  assign upd_fire    = upd_valid && upd_ready;
  assign pred_valid  = fetch_valid;
  assign fetch_ready = pred_ready;

  bp_dir_table #(.IDX_W(DIR_IDX_W)) u_dir (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (fetch_pc[DIR_IDX_W+LO-1:LO]),
    .rd_ctr   (ctr),
    .wr_en    (upd_fire),
    .wr_idx   (upd_pc[DIR_IDX_W+LO-1:LO]),
    .wr_taken (upd_taken)
  );

  bp_target_buf #(.PC_W(PC_W), .IDX_W(BTB_IDX_W)) u_btb (
    .clk    (clk),
    .rst    (rst),
    .rd_pc  (fetch_pc),
    .rd_hit (hit),
    .rd_tgt (btb_tgt),
    .wr_en  (upd_fire && upd_taken),
    .wr_pc  (upd_pc),
    .wr_tgt (upd_target)
  );

  always_comb begin
    pred_taken = ctr[1] && hit;
    pred_npc   = pred_taken ? btb_tgt : fetch_pc + PC_W'(4);
  end

  // R1: right after reset nothing is cached, so nothing is predicted taken
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !pred_taken);
  // R9: update port never stalls
  assert_upd_ready_R9: assert property (@(posedge clk) disable iff (rst) upd_ready);
endmodule

// File: tb/bp_fetch_predictor_tb.sv
`timescale 1ns/1ps
module bp_fetch_predictor_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_valid = 1'b0, pred_ready = 1'b0;
  logic        fetch_ready, pred_valid, pred_taken, upd_ready;
  logic [31:0] fetch_pc = '0, pred_npc;
  logic        upd_valid = 1'b0, upd_taken = 1'b0;
  logic [31:0] upd_pc = '0, upd_target = '0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [1:0]  m_ctr [64];
  logic        m_v   [16];
  logic [25:0] m_tag [16];
  logic [31:0] m_tgt [16];

  always #10 clk = ~clk;

  bp_fetch_predictor u_dut (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_pc(fetch_pc), .pred_valid(pred_valid), .pred_ready(pred_ready),
    .pred_taken(pred_taken), .pred_npc(pred_npc), .upd_valid(upd_valid),
    .upd_ready(upd_ready), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_target(upd_target)
  );

  function automatic logic exp_taken(input logic [31:0] pc);
    return m_ctr[pc[7:2]][1] && m_v[pc[5:2]] && (m_tag[pc[5:2]] == pc[31:6]);
  endfunction

  function automatic logic [31:0] exp_npc(input logic [31:0] pc);
    return exp_taken(pc) ? m_tgt[pc[5:2]] : pc + 32'd4;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 64; i++) m_ctr[i] = 2'b01;
    for (int i = 0; i < 16; i++) begin m_v[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0; end
  endtask

  task automatic model_update(input logic [31:0] pc, input logic t, input logic [31:0] tgt);
    logic [1:0] c;
    c = m_ctr[pc[7:2]];
    if (t) begin
      m_ctr[pc[7:2]] = (c == 2'b11) ? c : c + 2'd1;
      m_v[pc[5:2]] = 1'b1; m_tag[pc[5:2]] = pc[31:6]; m_tgt[pc[5:2]] = tgt;
    end else begin
      m_ctr[pc[7:2]] = (c == 2'b00) ? c : c - 2'd1;
    end
  endtask

  // One cycle: drive at falling edge, check the lookup, then the edge applies the update.
  task automatic cyc(input string req, input logic [31:0] pc, input logic uv,
                     input logic [31:0] upc, input logic ut, input logic [31:0] utgt);
    @(negedge clk);
    fetch_pc = pc; upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_target = utgt;
    #1;
    chk(req, {31'd0, pred_taken}, {31'd0, exp_taken(pc)});
    chk(req, pred_npc, exp_npc(pc));
    if (uv) model_update(upc, ut, utgt);
  endtask

  task automatic train(input logic [31:0] pc, input logic t, input logic [31:0] tgt);
    cyc("R2", pc, 1'b1, pc, t, tgt);
  endtask

  function automatic logic [31:0] rnd_pc();
    logic [31:0] hi [4] = '{32'h0000_1000, 32'h0000_2300, 32'h8000_0000, 32'h0004_0100};
    return hi[$urandom % 4] + {24'd0, 6'($urandom), 2'b00};
  endfunction

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b, t1, t2;
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: reset state
    cyc("R1", 32'h0000_1040, 1'b0, '0, 1'b0, '0);
    chk("R1", {31'd0, pred_taken}, 32'd0);
    chk("R1", pred_npc, 32'h0000_1044);

    // R9: stream pass-through and update ready
    @(negedge clk); fetch_valid = 1'b1; pred_ready = 1'b0; #1;
    chk("R9", {30'd0, pred_valid, fetch_ready}, {30'd0, 1'b1, 1'b0});
    chk("R9", {31'd0, upd_ready}, 32'd1);
    @(negedge clk); fetch_valid = 1'b0; pred_ready = 1'b1; #1;
    chk("R9", {30'd0, pred_valid, fetch_ready}, {30'd0, 1'b0, 1'b1});

    // R2 / R5: one taken update moves 01 -> 10 and fills the cache
    a = 32'h0000_1040; t1 = 32'h0000_5000;
    train(a, 1'b1, t1);
    cyc("R5", a, 1'b0, '0, 1'b0, '0);
    chk("R5", pred_npc, t1);
    train(a, 1'b1, t1); train(a, 1'b1, t1);   // saturate at 11
    // R7: first miss keeps taken, second flips
    train(a, 1'b0, '0);
    cyc("R7", a, 1'b0, '0, 1'b0, '0);
    chk("R7", {31'd0, pred_taken}, 32'd1);
    train(a, 1'b0, '0);
    cyc("R7", a, 1'b0, '0, 1'b0, '0);
    chk("R7", {31'd0, pred_taken}, 32'd0);
    // R6: not-taken updates did not clear the cache: one taken outcome restores the old target
    train(a, 1'b1, t1);
    cyc("R6", a, 1'b0, '0, 1'b0, '0);
    chk("R6", pred_npc, t1);

    // R3 / R4: b shares counter (bits 7:2) and cache slot, differs in tag
    b = a + 32'h100;
    cyc("R4", b, 1'b0, '0, 1'b0, '0);
    chk("R4", {31'd0, pred_taken}, 32'd0);
    train(b, 1'b0, '0); train(b, 1'b0, '0);
    cyc("R3", a, 1'b0, '0, 1'b0, '0);
    chk("R3", {31'd0, pred_taken}, 32'd0);

    // R8: lookup during an update to the same entries sees old target
    train(a, 1'b1, t1); train(a, 1'b1, t1);
    t2 = 32'h0000_7770;
    cyc("R8", a, 1'b1, a, 1'b1, t2);
    chk("R8", pred_npc, t1);
    cyc("R8", a, 1'b0, '0, 1'b0, '0);
    chk("R8", pred_npc, t2);

    // R2 floor: drive to 00 and hold
    repeat (4) train(a, 1'b0, '0);
    train(a, 1'b1, t1);
    cyc("R2", a, 1'b0, '0, 1'b0, '0);
    chk("R2", {31'd0, pred_taken}, 32'd0);

    // Random mix covering R2..R6, R8
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] p, u;
      p = rnd_pc(); u = ($urandom % 3 == 0) ? p : rnd_pc();
      cyc("R5", p, 1'($urandom % 2), u, 1'($urandom % 3 != 0), $urandom & 32'hFFFF_FFFC);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule